// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens an image along the secondary scan direction. For every pixel position it receives three vertically adjacent 8-bit samples at once: the sample from the line before the centre (the two-line-delayed tap), the centre-line sample (the one-line-delayed tap) and the sample from the line after it (the undelayed input). A line-delay memory upstream aligns the three taps. The block turns them into one corrected pixel.

The correction is the centre value plus a scaled second difference. The centre tap is doubled, the sum of the outer taps is subtracted from it, and the difference is multiplied by a programmable coefficient. The product is rounded and added back to the centre value, and the result is saturated to the 8-bit pixel range. Input and output are streams qualified by a valid bit. The datapath is three register stages deep, and the coefficient travels with the pixel it belongs to.

Top module: `vsharp_filter`

## Requirements
- R1: For a valid beat with outer taps P (`tap_prev`), C (`tap_cur`), centre M (`tap_mid`) and coefficient K, the output pixel is sat(M + rnd(K·(2M − (P + C)))), where all intermediate values are signed and never overflow.
- R2: `coef_k` is unsigned fixed point: bits [7:4] hold the integer part and bits [3:0] the fraction, so 0x10 is 1.0, 0x08 is 0.5 and 0x00 makes the output equal to M.
- R3: The scaled term is rounded to the nearest integer, and an exact half rounds toward plus infinity: +0.5 becomes +1 and −0.5 becomes 0.
- R4: A corrected value below 0 is output as 0.
- R5: A corrected value above 255 is output as 255.
- R6: `out_valid` rises exactly three rising clock edges after the edge that samples `in_valid` high, and `out_pix` in that cycle belongs to that beat. Gaps in the input stream appear as gaps of the same length at the output.
- R7: A synchronous active-high `rst` clears every pipeline valid bit, so `out_valid` is low from the edge after `rst` is seen high, including for beats that were in flight.
- R8: When all three taps are equal the output equals the centre tap, for any coefficient.
- R9: The coefficient is sampled on the same edge as the taps of its beat, so a coefficient that changes on every beat applies to each beat separately.
- R10: While `out_valid` is low, `out_pix` holds the last pixel that was output, whatever the taps carry on beats where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers sample on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | The taps and coefficient form a beat this cycle |
| tap_prev | input | 8 | Pixel from the preceding line (two-line-delayed tap) |
| tap_mid | input | 8 | Centre-line pixel (one-line-delayed tap) |
| tap_cur | input | 8 | Pixel from the following line (undelayed input) |
| coef_k | input | 8 | Sharpening coefficient, 4 integer and 4 fraction bits |
| out_valid | output | 1 | `out_pix` carries a corrected pixel |
| out_pix | output | 8 | Corrected, saturated pixel |

## Verification
A fault in the difference or scaling stage shows in `out_pix` three edges after the beat that carries it: a wrong sign or width turns a slight correction into saturation at 0 or 255, and a rounding fault moves the result by one on half-way products. Because the coefficient travels through the stages with its pixel, a misaligned stage register shows up on the second of two beats that share taps but differ in coefficient. A valid bit that is dropped or duplicated shows at once as a shifted or stretched `out_valid` pattern around a one-cycle input gap. A data register that loads without a valid beat shows up as `out_pix` changing during that gap.

// File: rtl/vsharp_pkg.sv
package vsharp_pkg;

    // Pixel and coefficient geometry
    localparam int PIX_W   = 8;
    localparam int K_INT   = 4;
    localparam int K_FRAC  = 4;

    // Derived widths
    localparam int K_W     = K_INT + K_FRAC;
    localparam int SUM_W   = PIX_W + 1;               // outer-tap sum
    localparam int DIFF_W  = PIX_W + 2;               // signed 2M - (P+C)
    localparam int PROD_W  = DIFF_W + K_W + 1;        // signed product
    localparam int SCL_W   = PROD_W - K_FRAC;         // after fraction drop
    localparam int ACC_W   = SCL_W + 1;               // centre + scaled
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int DIFF_LIM = 2 * PIX_MAX;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic [K_W-1:0]           coef_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SCL_W-1:0]  scl_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // Payload after the difference stage
    typedef struct packed {
        diff_t d2;
        pix_t  centre;
        coef_t gain;
    } stg1_t;

    // Payload after the scaling stage
    typedef struct packed {
        scl_t  corr;
        pix_t  centre;
    } stg2_t;

    // Second difference: twice the centre minus both outer taps
    function automatic diff_t second_diff(pix_t p, pix_t m, pix_t c);
        logic [SUM_W-1:0] outer;
        logic [SUM_W-1:0] twice;
        outer = SUM_W'(p) + SUM_W'(c);
        twice = {m, 1'b0};
        return diff_t'({1'b0, twice}) - diff_t'({1'b0, outer});
    endfunction

    // Drop the fraction bits, rounding halves toward plus infinity
    function automatic scl_t round_frac(prod_t p);
        prod_t biased;
        biased = p + prod_t'(1 << (K_FRAC - 1));
        return SCL_W'(biased >>> K_FRAC);
    endfunction

    // Saturate a signed accumulator into the pixel range
    function automatic pix_t sat_pix(acc_t a);
        if (a < 0)
            return '0;
        else if (a > acc_t'(PIX_MAX))
            return pix_t'(PIX_MAX);
        else
            return pix_t'(a);
    endfunction

endpackage

// File: rtl/vsharp_diff_stage.sv
module vsharp_diff_stage
    import vsharp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  v_in,
    input  pix_t  p_in,
    input  pix_t  m_in,
    input  pix_t  c_in,
    input  coef_t k_in,
    output logic  v_q,
    output stg1_t s_q
);

    diff_t d2_c;

    always_comb begin
        d2_c = second_diff(p_in, m_in, c_in);
    end

    always_ff @(posedge clk) begin
        if (rst)
            v_q <= 1'b0;
        else
            v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        if (v_in) begin
            s_q.d2     <= d2_c;
            s_q.centre <= m_in;
            s_q.gain   <= k_in;
        end
    end

    AST_DIFF_BOUND: assert property (@(posedge clk) disable iff (rst) // R1
        v_q |-> (s_q.d2 >= -diff_t'(DIFF_LIM) && s_q.d2 <= diff_t'(DIFF_LIM)));

    AST_S1_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) // R6
        !$past(rst) |-> (v_q == $past(v_in)));

    AST_S1_GAIN_TRACK: assert property (@(posedge clk) disable iff (rst) // R9
        v_in |=> (s_q.gain == $past(k_in)));

endmodule

// File: rtl/vsharp_scale_stage.sv
module vsharp_scale_stage
    import vsharp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  v_in,
    input  stg1_t s_in,
    output logic  v_q,
    output stg2_t s_q
);

    prod_t prod_c;
    scl_t  corr_c;

    always_comb begin
        prod_c = prod_t'(s_in.d2) * prod_t'($signed({1'b0, s_in.gain}));
        corr_c = round_frac(prod_c);
    end

    always_ff @(posedge clk) begin
        if (rst)
            v_q <= 1'b0;
        else
            v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        if (v_in) begin
            s_q.corr   <= corr_c;
            s_q.centre <= s_in.centre;
        end
    end

    AST_FLAT_NO_CORR: assert property (@(posedge clk) disable iff (rst) // R8
        (v_in && s_in.d2 == '0) |=> (s_q.corr == '0));

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst) // R2
        (v_in && s_in.gain == '0) |=> (s_q.corr == '0));

    AST_CORR_SIGN: assert property (@(posedge clk) disable iff (rst) // R3
        (v_in && s_in.d2 > 0) |=> (s_q.corr >= 0));

    AST_S2_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) // R6
        !$past(rst) |-> (v_q == $past(v_in)));

endmodule

// File: rtl/vsharp_sat_stage.sv
module vsharp_sat_stage
    import vsharp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  v_in,
    input  stg2_t s_in,
    output logic  v_q,
    output pix_t  pix_q
);

    acc_t acc_c;

    always_comb begin
        acc_c = acc_t'({1'b0, s_in.centre}) + acc_t'(s_in.corr);
    end

    always_ff @(posedge clk) begin
        if (rst)
            v_q <= 1'b0;
        else
            v_q <= v_in;
    end

    always_ff @(posedge clk) begin
        if (v_in)
            pix_q <= sat_pix(acc_c);
    end

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst) // R4
        (v_in && acc_c < 0) |=> (pix_q == '0));

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst) // R5
        (v_in && acc_c > acc_t'(PIX_MAX)) |=> (pix_q == pix_t'(PIX_MAX)));

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) // R10
        !v_in |=> $stable(pix_q));

    AST_S3_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) // R6
        !$past(rst) |-> (v_q == $past(v_in)));

endmodule

// File: rtl/vsharp_filter.sv
module vsharp_filter
    import vsharp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] tap_prev,
    input  logic [7:0] tap_mid,
    input  logic [7:0] tap_cur,
    input  logic [7:0] coef_k,
    output logic       out_valid,
    output logic [7:0] out_pix
);

    logic  v1, v2;
    stg1_t s1;
    stg2_t s2;

    vsharp_diff_stage u_diff (
        .clk  (clk),
        .rst  (rst),
        .v_in (in_valid),
        .p_in (tap_prev),
        .m_in (tap_mid),
        .c_in (tap_cur),
        .k_in (coef_k),
        .v_q  (v1),
        .s_q  (s1)
    );

    vsharp_scale_stage u_scale (
        .clk  (clk),
        .rst  (rst),
        .v_in (v1),
        .s_in (s1),
        .v_q  (v2),
        .s_q  (s2)
    );

    vsharp_sat_stage u_sat (
        .clk   (clk),
        .rst   (rst),
        .v_in  (v2),
        .s_in  (s2),
        .v_q   (out_valid),
        .pix_q (out_pix)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk) // R7
        rst |=> !out_valid);

    AST_CENTRE_CARRY: assert property (@(posedge clk) disable iff (rst) // R1
        v1 |=> (s2.centre == $past(s1.centre)));

endmodule

// File: tb/vsharp_filter_tb_top.sv
module vsharp_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] tap_prev = '0;
    logic [7:0] tap_mid  = '0;
    logic [7:0] tap_cur  = '0;
    logic [7:0] coef_k   = '0;
    logic       out_valid;
    logic [7:0] out_pix;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    vsharp_filter dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .tap_prev  (tap_prev),
        .tap_mid   (tap_mid),
        .tap_cur   (tap_cur),
        .coef_k    (coef_k),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // {valid, prev, mid, cur, coef, expected pixel}
    localparam int NV = 17;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'd100, 8'd100, 8'd100, 8'h30, 8'd100}, // R8 flat, K=3.0
        {1'b1, 8'd90,  8'd100, 8'd110, 8'h10, 8'd100}, // R1 linear ramp
        {1'b1, 8'd80,  8'd100, 8'd100, 8'h10, 8'd120}, // R1 K=1.0, R9 first
        {1'b1, 8'd80,  8'd100, 8'd100, 8'h08, 8'd110}, // R2 K=0.5, R9 second
        {1'b0, 8'd7,   8'd9,   8'd250, 8'hFF, 8'd0},   // R6/R10 gap
        {1'b1, 8'd0,   8'd100, 8'd0,   8'h10, 8'd255}, // R5 clamp high
        {1'b1, 8'd200, 8'd50,  8'd200, 8'h10, 8'd0},   // R4 clamp low
        {1'b1, 8'd0,   8'd0,   8'd0,   8'hFF, 8'd0},   // R8 all zero
        {1'b1, 8'd255, 8'd255, 8'd255, 8'hFF, 8'd255}, // R8 all full
        {1'b1, 8'd99,  8'd100, 8'd100, 8'h08, 8'd101}, // R3 +0.5 up
        {1'b1, 8'd101, 8'd100, 8'd100, 8'h08, 8'd100}, // R3 -0.5 to 0
        {1'b1, 8'd99,  8'd100, 8'd100, 8'h07, 8'd100}, // R3 +0.4375 down
        {1'b1, 8'd101, 8'd100, 8'd100, 8'h09, 8'd99},  // R3 -0.5625 to -1
        {1'b1, 8'd0,   8'd100, 8'd0,   8'h00, 8'd100}, // R2 K=0
        {1'b1, 8'd97,  8'd100, 8'd100, 8'h05, 8'd101}, // R3 0.9375 up
        {1'b1, 8'd40,  8'd50,  8'd40,  8'h1C, 8'd85},  // R2 K=1.75
        {1'b1, 8'd255, 8'd0,   8'd255, 8'hFF, 8'd0}    // R4 extreme negative
    };

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] p, input logic [7:0] m,
                         input logic [7:0] c, input logic [7:0] k);
        in_valid = v;
        tap_prev = p;
        tap_mid  = m;
        tap_cur  = c;
        coef_k   = k;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int last_pix;
        last_pix = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset state out_valid", int'(out_valid), 0);
        rst = 1'b0;

        // Table walk: beat c driven at negedge c, checked at negedge c+3
        for (int c = 0; c < NV + 3; c++) begin
            @(negedge clk);
            if (c >= 3) begin
                logic [40:0] e;
                e = VEC[c-3];
                chk($sformatf("R6 valid row %0d", c - 3), int'(out_valid), int'(e[40]));
                if (e[40]) begin
                    chk($sformatf("R1 pixel row %0d", c - 3), int'(out_pix), int'(e[7:0]));
                    last_pix = int'(e[7:0]);
                end else begin
                    chk($sformatf("R10 hold in gap row %0d", c - 3), int'(out_pix), last_pix);
                end
            end
            if (c < NV)
                drive(VEC[c][40], VEC[c][39:32], VEC[c][31:24], VEC[c][23:16], VEC[c][15:8]);
            else
                drive(1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        end

        // R10: one beat, then idle beats with busy taps
        @(negedge clk);
        drive(1'b1, 8'd80, 8'd100, 8'd100, 8'h10);
        @(negedge clk);
        drive(1'b0, 8'd0, 8'd255, 8'd0, 8'hFF);
        @(negedge clk);
        drive(1'b0, 8'd255, 8'd0, 8'd255, 8'hFF);
        @(negedge clk);
        chk("R6 single beat valid", int'(out_valid), 1);
        chk("R1 single beat pixel", int'(out_pix), 120);
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 8'(i * 40), 8'(255 - i), 8'(i), 8'hFF);
            @(negedge clk);
            chk("R10 idle valid low", int'(out_valid), 0);
            chk("R10 idle pixel held", int'(out_pix), 120);
        end

        // R7: reset while beats are in flight
        drive(1'b1, 8'd0, 8'd100, 8'd0, 8'h10);
        @(negedge clk);
        drive(1'b1, 8'd10, 8'd20, 8'd30, 8'h10);
        rst = 1'b1;
        @(negedge clk);
        drive(1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 flushed beat suppressed", int'(out_valid), 0);
        end

        // R9: coefficient alternates on every beat after reset
        drive(1'b1, 8'd80, 8'd100, 8'd100, 8'h20);
        @(negedge clk);
        drive(1'b1, 8'd80, 8'd100, 8'd100, 8'h00);
        @(negedge clk);
        drive(1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        @(negedge clk);
        chk("R9 beat K=2.0 valid", int'(out_valid), 1);
        chk("R9 beat K=2.0 pixel", int'(out_pix), 140);
        @(negedge clk);
        chk("R9 beat K=0 valid", int'(out_valid), 1);
        chk("R9 beat K=0 pixel", int'(out_pix), 100);
        @(negedge clk);
        chk("R6 trailing valid low", int'(out_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule